// File: doc/BRIEF.md
# Gated Serial Clock Divider

This block derives the serial flash clock from the controller's core clock. A two-bit select sets a power-of-two half period: the serial clock stays high for 2^s core cycles and low for 2^s core cycles. A run/stop gate starts and stops that clock only at a low level, so it never emits a shortened high pulse. The block also produces two one-cycle strobes for the neighbouring shifter. The shift strobe marks each falling edge. The sample strobe marks either the rising edge or the middle of the low phase, chosen by a phase bit.

Software drives a small control register. It clears the enable bit, waits until `sclk_stopped` and `eng_idle` are both high (`cfg_safe`), writes a new select and phase, then sets the enable again and waits for `sclk_stopped` to drop. Select and phase writes are dropped unless the gate is stopped and the stored enable is 0. This keeps the active divider constant while the clock runs. The gate is a four-state machine:

- HALT: clock parked low. HALT→LAUNCH when enable is set.
- LAUNCH: the select and phase are copied into the active copy. LAUNCH→RUN when enable is still set; LAUNCH→HALT when it was withdrawn.
- RUN: the clock toggles.
  - RUN→HALT when enable is clear and the clock is low, or when a high phase ends with enable clear.
  - RUN→DRAIN when enable is clear in the middle of a high phase.
- DRAIN: the current high phase runs to its end. DRAIN→HALT when it ends.

Top module: `sclk_gate_div`

## Requirements
- R1: After reset `sclk` is 0, `sclk_stopped` is 1, `ctrl_q` is 0, `eng_idle` is 1 and both strobes are 0.
- R2: The select field sits at bits 9:8. A value s gives high and low phases of 2^s core cycles each while running (0→1, 1→2, 2→4, 3→8).
- R3: Bit 0 is the enable. A write that sets it while stopped makes `sclk_stopped` fall on the second clock edge after the write edge. The first rise of `sclk` follows 2^s cycles later.
- R4: Once a cleared enable is seen, the gate stops.
  - If `sclk` is low, `sclk_stopped` rises on the next edge.
  - If `sclk` is high, the high phase completes and `sclk_stopped` rises on the same edge that `sclk` falls.
  - `sclk` is 0 whenever `sclk_stopped` is 1.
- R5: `sclk_stopped` clears only when the clock starts running, and `sclk` is 0 at that moment.
- R6: The select field (bits 9:8) and the phase bit (bit 12) are written only when, at the write edge, `sclk_stopped` is 1 and the stored enable is 0. Otherwise they keep their value. The enable bit is written on every write. `ctrl_q` returns bits 0, 9:8 and 12, with every other bit 0.
- R7: `eng_idle` is `eng_busy` inverted, one cycle late. `cfg_safe` is high exactly when `eng_idle` and `sclk_stopped` are both high.
- R8: Every high pulse of `sclk` lasts exactly 2^s core cycles.
- R9: With phase bit 0, `shift_stb` pulses in the cycle where `sclk` goes low and `smp_stb` pulses in the cycle where `sclk` goes high.
- R10: With phase bit 1 and s>0, `smp_stb` pulses 2^(s-1) cycles into each low phase, a quarter period before the rise. With s=0 it pulses with the rise.
- R11: An enable withdrawn during LAUNCH returns the gate to HALT without any `sclk` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control write data (enable bit 0, select 9:8, phase bit 12) |
| eng_busy | input | 1 | Transfer engine has a serial transfer in progress |
| ctrl_q | output | 16 | Control register contents |
| sclk | output | 1 | Gated, divided serial clock |
| sclk_stopped | output | 1 | Serial clock is parked low |
| eng_idle | output | 1 | Registered inverse of `eng_busy` |
| cfg_safe | output | 1 | Idle and stopped together: reconfiguration allowed |
| shift_stb | output | 1 | One-cycle pulse on each falling edge of `sclk` |
| smp_stb | output | 1 | One-cycle sample pulse placed by the phase bit |

## Verification
A wrong divide count or a corrupted active select shows at `sclk` within one half period, as a high or low phase of the wrong length. A state machine left in RUN or DRAIN shows as `sclk_stopped` failing to rise within 2^s+1 cycles of a cleared enable. A HALT entered too early shows as a high pulse shorter than 2^s. A select or phase written while running shows on `ctrl_q` on the very next cycle. A latched phase error shows at the first low phase after LAUNCH, as a sample strobe off by a quarter period. The reference model tracks every output each cycle, so any of these faults is caught on the cycle it first appears.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;

    // Gate controller states
    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_RUN    = 2'd2,
        ST_DRAIN  = 2'd3
    } gate_state_e;

    // Control register layout
    localparam int unsigned CTRL_W  = 16;
    localparam int unsigned EN_BIT  = 0;
    localparam int unsigned SEL_LSB = 8;
    localparam int unsigned PHA_BIT = 12;

endpackage

// File: rtl/sclkdiv_ctrl.sv
module sclkdiv_ctrl
    import sclkdiv_pkg::*;
#(
    parameter int unsigned SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              stopped_i,
    input  logic              busy_i,
    output logic              en_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              pha_o,
    output logic              idle_o,
    output logic [CTRL_W-1:0] rd_o
);

    logic cfg_open;
    logic wdata_unused;

    // Select and phase may change only while parked with enable off
    assign cfg_open     = stopped_i & ~en_o;
    assign wdata_unused = ^wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o   <= 1'b0;
            sel_o  <= '0;
            pha_o  <= 1'b0;
            idle_o <= 1'b1;
        end else begin
            idle_o <= ~busy_i;
            if (wr_en) begin
                en_o <= wr_data[EN_BIT];
                if (cfg_open) begin
                    sel_o <= wr_data[SEL_LSB +: SEL_W];
                    pha_o <= wr_data[PHA_BIT];
                end
            end
        end
    end

    always_comb begin
        rd_o                    = '0;
        rd_o[EN_BIT]            = en_o;
        rd_o[SEL_LSB +: SEL_W]  = sel_o;
        rd_o[PHA_BIT]           = pha_o;
    end

endmodule

// File: rtl/sclkdiv_gate_fsm.sv
module sclkdiv_gate_fsm
    import sclkdiv_pkg::*;
#(
    parameter int unsigned SEL_W = 2,
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             pha_i,
    output gate_state_e      state_o,
    output logic             sclk_o,
    output logic             rise_o,
    output logic             fall_o,
    output logic             mid_o,
    output logic [SEL_W-1:0] sel_act_o,
    output logic             pha_act_o
);

    gate_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, last_cnt, mid_cnt;
    logic [CNT_W:0]   half_len;
    logic             sclk_q, sclk_d, at_last, latch;
    logic [SEL_W-1:0] sel_q;
    logic             pha_q;

    // Half-period bookkeeping from the active select
    always_comb begin
        half_len = (CNT_W+1)'(1) << sel_q;
        last_cnt = half_len[CNT_W-1:0] - CNT_W'(1);
        mid_cnt  = half_len[CNT_W:1];
        cnt_inc  = cnt_q + CNT_W'(1);
        at_last  = (cnt_q == last_cnt);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            cnt_q   <= '0;
            sclk_q  <= 1'b0;
            sel_q   <= '0;
            pha_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sclk_q  <= sclk_d;
            if (latch) begin
                sel_q <= sel_i;
                pha_q <= pha_i;
            end
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:   if (en_i) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = en_i ? ST_RUN : ST_HALT;
            ST_RUN: begin
                if (!en_i) begin
                    if (!sclk_q || at_last) state_d = ST_HALT;
                    else                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN:  if (at_last) state_d = ST_HALT;
        endcase
    end

    // Counter, clock level and edge flags
    always_comb begin
        cnt_d  = cnt_q;
        sclk_d = sclk_q;
        rise_o = 1'b0;
        fall_o = 1'b0;
        mid_o  = 1'b0;
        latch  = 1'b0;
        unique case (state_q)
            ST_HALT: begin
                cnt_d  = '0;
                sclk_d = 1'b0;
            end
            ST_LAUNCH: begin
                cnt_d = '0;
                latch = 1'b1;
            end
            ST_RUN: begin
                if (!en_i && !sclk_q) begin
                    cnt_d = '0;
                end else if (at_last) begin
                    cnt_d  = '0;
                    sclk_d = ~sclk_q;
                    rise_o = ~sclk_q;
                    fall_o = sclk_q;
                end else begin
                    cnt_d = cnt_inc;
                    mid_o = ~sclk_q && (cnt_inc == mid_cnt);
                end
            end
            ST_DRAIN: begin
                if (at_last) begin
                    cnt_d  = '0;
                    sclk_d = 1'b0;
                    fall_o = 1'b1;
                end else begin
                    cnt_d = cnt_inc;
                end
            end
        endcase
    end

    assign state_o   = state_q;
    assign sclk_o    = sclk_q;
    assign sel_act_o = sel_q;
    assign pha_act_o = pha_q;

endmodule

// File: rtl/sclkdiv_strobe.sv
module sclkdiv_strobe #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             mid_i,
    input  logic             pha_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             shift_o,
    output logic             smp_o
);

    logic smp_d;

    // Quarter-period placement needs at least two cycles per half period
    always_comb begin
        if (pha_i && (sel_i != '0)) smp_d = mid_i;
        else                        smp_d = rise_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_o <= 1'b0;
            smp_o   <= 1'b0;
        end else begin
            shift_o <= fall_i;
            smp_o   <= smp_d;
        end
    end

endmodule

// File: rtl/sclk_gate_div.sv
module sclk_gate_div
    import sclkdiv_pkg::*;
#(
    parameter int unsigned SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic              eng_busy,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              sclk,
    output logic              sclk_stopped,
    output logic              eng_idle,
    output logic              cfg_safe,
    output logic              shift_stb,
    output logic              smp_stb
);

    localparam int unsigned CNT_W = (1 << SEL_W) - 1;

    gate_state_e      gate_state;
    logic             en_r, pha_r, pha_act;
    logic [SEL_W-1:0] sel_r, sel_act;
    logic             rise_p, fall_p, mid_p;

    assign sclk_stopped = (gate_state == ST_HALT) || (gate_state == ST_LAUNCH);
    assign cfg_safe     = eng_idle & sclk_stopped;

    sclkdiv_ctrl #(.SEL_W(SEL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_data   (cfg_wdata),
        .stopped_i (sclk_stopped),
        .busy_i    (eng_busy),
        .en_o      (en_r),
        .sel_o     (sel_r),
        .pha_o     (pha_r),
        .idle_o    (eng_idle),
        .rd_o      (ctrl_q)
    );

    sclkdiv_gate_fsm #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_r),
        .sel_i     (sel_r),
        .pha_i     (pha_r),
        .state_o   (gate_state),
        .sclk_o    (sclk),
        .rise_o    (rise_p),
        .fall_o    (fall_p),
        .mid_o     (mid_p),
        .sel_act_o (sel_act),
        .pha_act_o (pha_act)
    );

    sclkdiv_strobe #(.SEL_W(SEL_W)) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise_p),
        .fall_i  (fall_p),
        .mid_i   (mid_p),
        .pha_i   (pha_act),
        .sel_i   (sel_act),
        .shift_o (shift_stb),
        .smp_o   (smp_stb)
    );

endmodule

// File: rtl/sclk_gate_div_chk.sv
module sclk_gate_div_chk #(
    parameter int unsigned SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sclk,
    input logic             sclk_stopped,
    input logic [SEL_W-1:0] sel_i,
    input logic             eng_busy,
    input logic             eng_idle,
    input logic             shift_stb,
    input logic             smp_stb
);

    int hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_len <= 0;
        else        hi_len <= sclk ? hi_len + 1 : 0;
    end

    a_r4_low_while_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_stopped |-> !sclk);

    a_r5_restart_from_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_stopped) |-> !sclk);

    a_r6_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_stopped |=> $stable(sel_i));

    a_r7_idle_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> !eng_idle);

    a_r7_idle_free: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |=> eng_idle);

    a_r8_full_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_len == (1 << sel_i)));

    a_r9_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |-> $fell(sclk));

    a_r9_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_stb && smp_stb));

endmodule

bind sclk_gate_div sclk_gate_div_chk #(.SEL_W(SEL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk         (sclk),
    .sclk_stopped (sclk_stopped),
    .sel_i        (ctrl_q[sclkdiv_pkg::SEL_LSB +: SEL_W]),
    .eng_busy     (eng_busy),
    .eng_idle     (eng_idle),
    .shift_stb    (shift_stb),
    .smp_stb      (smp_stb)
);

// File: tb/sclk_gate_div_tb_top.sv
`timescale 1ns/1ps
module sclk_gate_div_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        eng_busy = 1'b0;
    logic [15:0] ctrl_q;
    logic        sclk, sclk_stopped, eng_idle, cfg_safe, shift_stb, smp_stb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    int m_state = 0;  // 0 halt, 1 launch, 2 run, 3 drain
    int m_cnt = 0;
    int m_sclk = 0;
    int m_en = 0, m_div = 0, m_pha = 0;
    int m_adiv = 0, m_apha = 0;
    int m_idle = 1, m_shift = 0, m_smp = 0;
    int m_smp_r10 = 0;
    int hi_cnt = 0, prev_sclk = 0, prev_stopped = 1, rises = 0;

    always #2 clk = ~clk;

    sclk_gate_div dut_i (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .eng_busy (eng_busy), .ctrl_q (ctrl_q), .sclk (sclk),
        .sclk_stopped (sclk_stopped), .eng_idle (eng_idle), .cfg_safe (cfg_safe),
        .shift_stb (shift_stb), .smp_stb (smp_stb)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] cw(input int en, input int sel, input int pha);
        return 16'((en & 1) | ((sel & 3) << 8) | ((pha & 1) << 12));
    endfunction

    task automatic ref_tick();
        int h, nst, ncnt, nsclk, rise, fall, mid, was_stopped;
        h = 1 << m_adiv;
        nst = m_state; ncnt = m_cnt; nsclk = m_sclk;
        rise = 0; fall = 0; mid = 0;
        was_stopped = (m_state <= 1);
        if (m_state == 0) begin
            ncnt = 0; nsclk = 0;
            if (m_en != 0) nst = 1;
        end else if (m_state == 1) begin
            ncnt = 0;
            nst = (m_en != 0) ? 2 : 0;
        end else if (m_state == 2) begin
            if (m_en == 0 && m_sclk == 0) begin
                nst = 0; ncnt = 0;
            end else if (m_cnt == h - 1) begin
                ncnt = 0; nsclk = 1 - m_sclk;
                if (m_sclk != 0) fall = 1; else rise = 1;
                if (m_en == 0) nst = 0;
            end else begin
                ncnt = m_cnt + 1;
                if (m_en == 0) nst = 3;
                if (m_sclk == 0 && ncnt == h / 2) mid = 1;
            end
        end else begin
            if (m_cnt == h - 1) begin
                ncnt = 0; nsclk = 0; fall = 1; nst = 0;
            end else ncnt = m_cnt + 1;
        end
        m_shift = fall;
        m_smp = (m_apha != 0 && m_adiv != 0) ? mid : rise;
        m_smp_r10 = m_apha;
        if (m_state == 1) begin m_adiv = m_div; m_apha = m_pha; end
        m_state = nst; m_cnt = ncnt; m_sclk = nsclk;
        if (cfg_we) begin
            if (was_stopped != 0 && m_en == 0) begin
                m_div = int'(cfg_wdata[9:8]);
                m_pha = int'(cfg_wdata[12]);
            end
            m_en = int'(cfg_wdata[0]);
        end
        m_idle = eng_busy ? 0 : 1;
    endtask

    task automatic compare();
        chk("R2", "sclk", int'(sclk), m_sclk);
        chk("R4", "sclk_stopped", int'(sclk_stopped), (m_state <= 1) ? 1 : 0);
        chk("R6", "ctrl_q", int'(ctrl_q), m_en | (m_div << 8) | (m_pha << 12));
        chk("R7", "eng_idle", int'(eng_idle), m_idle);
        chk("R7", "cfg_safe", int'(cfg_safe), (m_idle != 0 && m_state <= 1) ? 1 : 0);
        chk("R9", "shift_stb", int'(shift_stb), m_shift);
        if (m_smp_r10 != 0) chk("R10", "smp_stb", int'(smp_stb), m_smp);
        else                chk("R9", "smp_stb", int'(smp_stb), m_smp);
        if (sclk) hi_cnt++;
        else if (prev_sclk != 0) begin
            chk("R8", "high pulse length", hi_cnt, 1 << m_adiv);
            hi_cnt = 0;
        end
        if (sclk && prev_sclk == 0) rises++;
        if (prev_stopped != 0 && !sclk_stopped) chk("R5", "sclk at restart", int'(sclk), 0);
        prev_sclk = int'(sclk);
        prev_stopped = int'(sclk_stopped);
    endtask

    task automatic step();
        @(posedge clk);
        ref_tick();
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [15:0] d);
        cfg_we = 1'b1;
        cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic wait_level(input logic lvl);
        for (int i = 0; i < 40 && sclk != lvl; i++) step();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "sclk", int'(sclk), 0);
        chk("R1", "sclk_stopped", int'(sclk_stopped), 1);
        chk("R1", "ctrl_q", int'(ctrl_q), 0);
        chk("R1", "eng_idle", int'(eng_idle), 1);
        chk("R1", "strobes", int'(shift_stb) + int'(smp_stb), 0);

        // R3 enable timing, select 0
        wr(cw(1, 0, 0));
        chk("R3", "stopped after write edge", int'(sclk_stopped), 1);
        step();
        chk("R3", "stopped during launch", int'(sclk_stopped), 1);
        step();
        chk("R3", "stopped cleared", int'(sclk_stopped), 0);
        run(12);

        // R6 select write while running is dropped, enable still taken
        wr(cw(0, 3, 1));
        run(6);
        chk("R6", "select after running write", int'(ctrl_q[9:8]), 0);
        chk("R4", "stopped after clear", int'(sclk_stopped), 1);

        // Reconfigure while stopped: select 2, phase 1
        wr(cw(1, 2, 1));
        run(20);
        eng_busy = 1'b1;
        run(3);
        eng_busy = 1'b0;
        run(10);
        // R4 stop in the middle of a high phase
        wait_level(1'b1);
        step();
        wr(cw(0, 2, 1));
        run(10);

        // Select 3, phase 0, stop during low phase
        wr(cw(1, 3, 0));
        run(40);
        wait_level(1'b0);
        wr(cw(0, 3, 0));
        run(4);

        // Select 1, phase 1
        wr(cw(1, 1, 1));
        run(30);
        wr(cw(0, 1, 1));
        run(6);

        // Select 0, phase 1 falls back to the rising edge
        wr(cw(1, 0, 1));
        run(10);
        wr(cw(0, 0, 1));
        run(4);

        // R11 enable withdrawn during launch
        rises = 0;
        wr(cw(1, 2, 0));
        wr(cw(0, 2, 0));
        run(12);
        chk("R11", "sclk rises after aborted launch", rises, 0);
        chk("R11", "stopped after aborted launch", int'(sclk_stopped), 1);

        eng_busy = 1'b1;
        run(2);
        chk("R7", "cfg_safe while busy", int'(cfg_safe), 0);
        eng_busy = 1'b0;
        run(2);
        summary();
    end

endmodule